// File: doc/BRIEF.md
# Compare-Match Timer with Selectable Wrap Point

This block is a 16-bit up-counter with three output-compare channels. On every cycle that the count enable is high, the counter steps by one. When it reaches the selected TOP value it returns to zero. A run-time select input chooses the TOP value from these sources: the full 16-bit range, three fixed limits of 8, 9 or 10 bits, the active compare value of the first channel, or an externally captured value.

Each channel holds a pending compare value and an active compare value. Software writes only the pending copy. The active copy takes the pending value when the counter wraps, so a new threshold never starts partway through a period. When the counter equals a channel's active value, the block sets that channel's flag and applies the channel's selected action to its waveform pin. The action can toggle the pin, clear it or set it, which gives both PWM and variable-frequency outputs. A force strobe applies the pin action without a match and without setting a flag. The block raises an interrupt request from any enabled flag. Writing a one to a flag clears it.

Top module: `timer_cmp_pwm`

## Requirements
- R1: After synchronous reset the count, every compare flag, the overflow flag, every waveform pin and the interrupt request are all 0.
- R2: While `cnt_en` is 1 the count rises by one per clock. While it is 0 the count holds its value.
- R3: `wrap_sel` selects TOP as follows: 1 = 0x00FF, 2 = 0x01FF, 3 = 0x03FF, 4 = the active value of channel 0, 5 = `cap_val`, and 0, 6 or 7 = 0xFFFF. On the enabled clock at which count equals TOP, the count becomes 0.
- R4: `ovf_flag` becomes 1 on the same edge that takes the count from TOP to 0. It stays 1 until `flag_clr[3]` is 1. When a set and a clear fall on the same clock, the set wins.
- R5: On an enabled clock at which count equals the active value of channel i, `cmp_flag[i]` becomes 1. It is visible while the count shows that value plus one. `flag_clr[i]` = 1 clears it.
- R6: `cmp_wr[i]` stores `cmp_wdata` in the pending copy of channel i. The active copy loads the pending copy only on the wrap edge and is unchanged otherwise.
- R7: Field `out_mode[2i+1:2i]` selects the pin action of channel i: 00 drives the pin to 0 on the next clock, 01 toggles it on a match, 10 clears it on a match, and 11 sets it on a match.
- R8: `force_cmp[i]` = 1 applies channel i's pin action on that clock. It leaves `cmp_flag[i]` and the count unaffected.
- R9: `irq` is 1 on the clock after any flag (bits 0..2 compare, bit 3 overflow) and its matching `irq_en` bit are both 1.
- R10: While `wrap_sel` = 4, the set and clear actions of channel 0 leave its pin unchanged. Toggle still works and flag 0 is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable |
| wrap_sel | input | 3 | TOP source select |
| cap_val | input | 16 | Captured value used as TOP when selected |
| cmp_wr | input | 3 | Per-channel write strobe for the pending compare value |
| cmp_wdata | input | 16 | Compare value to write |
| force_cmp | input | 3 | Per-channel forced pin action |
| out_mode | input | 6 | Two-bit pin action per channel |
| flag_clr | input | 4 | Write-one-to-clear for flags (3 = overflow) |
| irq_en | input | 4 | Interrupt enables, same bit order as flag_clr |
| count | output | 16 | Counter value |
| cmp_flag | output | 3 | Compare-match flags |
| ovf_flag | output | 1 | Wrap flag |
| wave | output | 3 | Waveform pins |
| irq | output | 1 | Interrupt request |

## Verification
Each of these results appears one clock after its cause: a match sets its flag and moves its pin, a wrap sets the overflow flag and reloads the active values, and a force moves its pin. The interrupt request appears one clock after the flag it reflects. The bench drives inputs and samples outputs on the falling edge. It waits for the count to show the compare value plus one before it checks a match result, and it checks the overflow flag when the count reads zero. Wrap points are measured as the peak count seen before the overflow flag rises.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } wave_act_e;

  typedef enum logic [2:0] {
    TOP_FULL = 3'd0,
    TOP_B8   = 3'd1,
    TOP_B9   = 3'd2,
    TOP_B10  = 3'd3,
    TOP_CMP0 = 3'd4,
    TOP_CAPT = 3'd5
  } top_sel_e;

  localparam int SEL_W = 3;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     cmp0_val,
  input  logic [W-1:0]     cap_val,
  input  logic             ovf_clr,
  output logic [W-1:0]     count,
  output logic             wrap,
  output logic             ovf_flag
);
  localparam logic [W-1:0] LIM8  = W'((1 << 8) - 1);
  localparam logic [W-1:0] LIM9  = W'((1 << 9) - 1);
  localparam logic [W-1:0] LIM10 = W'((1 << 10) - 1);
  localparam logic [W-1:0] LIMF  = '1;

  logic [W-1:0] top_val;

  always_comb begin
    case (top_sel_e'(sel))
      TOP_B8:   top_val = LIM8;
      TOP_B9:   top_val = LIM9;
      TOP_B10:  top_val = LIM10;
      TOP_CMP0: top_val = cmp0_val;
      TOP_CAPT: top_val = cap_val;
      default:  top_val = LIMF;
    endcase
  end

  assign wrap = cnt_en && (count == top_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (wrap)        count <= '0;
      else if (cnt_en) count <= count + 1'b1;
      if (wrap)         ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  assert_wrap_bottom_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == top_val) |=> (count == '0));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count));
  assert_ovf_set_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == top_val) |=> ovf_flag);
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic [W-1:0] count,
  input  logic         wrap,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         force_cmp,
  input  logic [1:0]   mode,
  input  logic         lock_pwm,
  input  logic         flag_clr,
  output logic [W-1:0] active,
  output logic         flag,
  output logic         wave
);
  logic [W-1:0] pending;
  logic         match;
  logic         fire;

  assign match = cnt_en && (count == active);
  assign fire  = match || force_cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      active  <= '0;
      flag    <= 1'b0;
      wave    <= 1'b0;
    end else begin
      if (wr_en) pending <= wdata;
      if (wrap)  active  <= pending;
      if (match)         flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      case (wave_act_e'(mode))
        ACT_OFF:    wave <= 1'b0;
        ACT_TOGGLE: if (fire) wave <= ~wave;
        ACT_CLEAR:  if (fire && !lock_pwm) wave <= 1'b0;
        default:    if (fire && !lock_pwm) wave <= 1'b1;
      endcase
    end
  end

  assert_match_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == active) |=> flag);
  assert_active_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(active));
  assert_off_low_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> !wave);
  assert_force_noflag_R8: assert property (@(posedge clk) disable iff (rst)
    (force_cmp && !flag && !(cnt_en && count == active)) |=> !flag);
  assert_lock_R10: assert property (@(posedge clk) disable iff (rst)
    (lock_pwm && mode[1]) |=> $stable(wave));
endmodule

// File: rtl/timer_cmp_pwm.sv
module timer_cmp_pwm
  import tmr_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [SEL_W-1:0] wrap_sel,
  input  logic [W-1:0]     cap_val,
  input  logic [NCH-1:0]   cmp_wr,
  input  logic [W-1:0]     cmp_wdata,
  input  logic [NCH-1:0]   force_cmp,
  input  logic [2*NCH-1:0] out_mode,
  input  logic [NCH:0]     flag_clr,
  input  logic [NCH:0]     irq_en,
  output logic [W-1:0]     count,
  output logic [NCH-1:0]   cmp_flag,
  output logic             ovf_flag,
  output logic [NCH-1:0]   wave,
  output logic             irq
);
  logic [W-1:0] act_val [NCH];
  logic         wrap;
  logic         top_is_cmp0;
  logic [NCH:0] all_flags;

  assign top_is_cmp0 = (wrap_sel == SEL_W'(TOP_CMP0));

  tmr_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .sel      (wrap_sel),
    .cmp0_val (act_val[0]),
    .cap_val  (cap_val),
    .ovf_clr  (flag_clr[NCH]),
    .count    (count),
    .wrap     (wrap),
    .ovf_flag (ovf_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic lock;
    assign lock = (i == 0) && top_is_cmp0;
    tmr_cmp_chan #(.W(W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .cnt_en    (cnt_en),
      .count     (count),
      .wrap      (wrap),
      .wr_en     (cmp_wr[i]),
      .wdata     (cmp_wdata),
      .force_cmp (force_cmp[i]),
      .mode      (out_mode[2*i +: 2]),
      .lock_pwm  (lock),
      .flag_clr  (flag_clr[i]),
      .active    (act_val[i]),
      .flag      (cmp_flag[i]),
      .wave      (wave[i])
    );
  end

  assign all_flags = {ovf_flag, cmp_flag};

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(all_flags & irq_en);
  end

  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (rst)
    (|({ovf_flag, cmp_flag} & irq_en)) |=> irq);
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(|({ovf_flag, cmp_flag} & irq_en)) |=> !irq);
endmodule

// File: tb/timer_cmp_pwm_bench.sv
module timer_cmp_pwm_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cnt_en;
  logic [2:0]  wrap_sel;
  logic [15:0] cap_val;
  logic [2:0]  cmp_wr;
  logic [15:0] cmp_wdata;
  logic [2:0]  force_cmp;
  logic [5:0]  out_mode;
  logic [3:0]  flag_clr;
  logic [3:0]  irq_en;
  logic [15:0] count;
  logic [2:0]  cmp_flag;
  logic        ovf_flag;
  logic [2:0]  wave;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  timer_cmp_pwm u_timer_cmp_pwm (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wrap_sel(wrap_sel),
    .cap_val(cap_val), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .force_cmp(force_cmp), .out_mode(out_mode), .flag_clr(flag_clr),
    .irq_en(irq_en), .count(count), .cmp_flag(cmp_flag),
    .ovf_flag(ovf_flag), .wave(wave), .irq(irq)
  );

  // {sel, cap_val, compare A value, expected TOP}
  localparam logic [50:0] VEC [0:4] = '{
    {3'd1, 16'h0000, 16'h0000, 16'h00FF},
    {3'd2, 16'h0000, 16'h0000, 16'h01FF},
    {3'd3, 16'h0000, 16'h0000, 16'h03FF},
    {3'd4, 16'h0000, 16'h0123, 16'h0123},
    {3'd5, 16'h0040, 16'h0000, 16'h0040}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_count(input logic [15:0] v);
    step();
    while (count != v) step();
  endtask

  task automatic write_cmp(input int ch, input logic [15:0] v);
    cmp_wr = 3'b001 << ch; cmp_wdata = v;
    step();
    cmp_wr = '0;
  endtask

  task automatic clear_flags();
    flag_clr = 4'hF;
    step();
    flag_clr = 4'h0;
  endtask

  task automatic measure(output logic [15:0] peak);
    clear_flags();
    peak = count;
    while (!ovf_flag) begin
      if (count > peak) peak = count;
      step();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cnt_en = 1'b0;
    step(); step();
    rst = 1'b0;
    step();
  endtask

  initial begin
    for (int n = 0; n < 190000; n++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pk;
    wrap_sel = 3'd1; cap_val = '0; cmp_wr = '0; cmp_wdata = '0;
    force_cmp = '0; out_mode = '0; flag_clr = '0; irq_en = '0;
    do_reset();

    // R1 reset state, R2 hold while disabled
    chk("R1 count", count, 0);
    chk("R1 flags", {ovf_flag, cmp_flag}, 0);
    chk("R1 wave/irq", {wave, irq}, 0);
    step(); step();
    chk("R2 hold", count, 0);

    write_cmp(0, 16'h0020);
    write_cmp(1, 16'h0040);
    write_cmp(2, 16'h0060);
    cnt_en = 1'b1;
    wait_count(16'h0005);
    clear_flags();
    wait_count(16'h0025);
    chk("R6 pending not active", cmp_flag[0], 0);
    chk("R2 counting", count, 16'h0025);
    wait_count(16'h0000);
    chk("R4 ovf set at wrap", ovf_flag, 1);
    clear_flags();
    chk("R4 ovf cleared", ovf_flag, 0);

    out_mode = 6'b11_11_01; irq_en = 4'b0001;
    force_cmp = 3'b010; step(); force_cmp = '0;
    chk("R8 force sets pin", wave[1], 1);
    chk("R8 force no flag", cmp_flag[1], 0);
    out_mode = 6'b11_10_01;
    wait_count(16'h0021);
    chk("R5 flag A", cmp_flag[0], 1);
    chk("R7 toggle", wave[0], 1);
    step();
    chk("R9 irq raised", irq, 1);
    wait_count(16'h0041);
    chk("R7 clear", wave[1], 0);
    chk("R5 flag B", cmp_flag[1], 1);
    wait_count(16'h0061);
    chk("R7 set", wave[2], 1);
    irq_en = 4'b0000; step();
    chk("R9 irq off", irq, 0);
    wait_count(16'h0021);
    chk("R7 toggle back", wave[0], 0);
    out_mode = 6'b00_10_01; step();
    chk("R7 off low", wave[2], 0);

    wait_count(16'h0000);
    wrap_sel = 3'd4; out_mode = 6'b00_10_11;
    measure(pk);
    chk("R3 top=cmpA", pk, 16'h0020);
    chk("R10 set locked", wave[0], 0);
    chk("R10 flag still set", cmp_flag[0], 1);
    out_mode = 6'b00_10_01;
    measure(pk);
    chk("R10 toggle allowed", wave[0], 1);

    for (int v = 0; v < 5; v++) begin
      do_reset();
      wrap_sel = VEC[v][50:48];
      cap_val  = VEC[v][47:32];
      write_cmp(0, VEC[v][31:16]);
      cnt_en = 1'b1;
      measure(pk);
      measure(pk);
      chk("R3 table top", pk, VEC[v][15:0]);
      chk("R3 bottom after wrap", count, 0);
    end

    do_reset();
    wrap_sel = 3'd0; cnt_en = 1'b1;
    measure(pk);
    chk("R3 full range top", pk, 16'hFFFF);
    chk("R4 ovf at max", ovf_flag, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule